// File: doc/BRIEF.md
# PECI Host Controller Register Front End

This block is the software-visible side of a PECI host controller. It sits on a simple 32-bit register bus with word addressing. It holds the configuration words that a separate bus engine reads: control, timing negotiation periods, target address and lengths, and expected FCS values. It also holds two byte buffers. The transmit buffer is filled by software and read by the engine one byte at a time. The receive buffer is filled by the engine one byte at a time and read by software.

A transaction starts when software writes a 1 to bit 0 of the command word while the engine is idle. A launch state machine then holds a start request towards the engine until the engine answers with busy. It then waits for the engine's command-done event. Every event from the engine is latched into a sticky status word. Software clears a status bit by writing 1 to it. A set of enable bits selects which status bits drive the interrupt line.

The launch state machine has three states. **LS_IDLE** moves to **LS_LAUNCH** on an accepted fire request. **LS_LAUNCH** drives the start request. It moves to **LS_WAIT** when busy is seen, or back to **LS_IDLE** if done arrives first. **LS_WAIT** moves back to **LS_IDLE** on the done event.

Top module: `peci_host_regs`

## Requirements
- R1: After reset every readable word returns zero, the interrupt is low and no start request is driven. The word map is: 0x00 control, 0x04 timing, 0x08 command, 0x0C length/address, 0x10 expected FCS, 0x14 captured FCS, 0x18 interrupt enable, 0x1C interrupt status. The port `bus_addr` carries byte offset / 4.
- R2: The transmit buffer holds 32 bytes, packed little-endian (byte 4k in bits [7:0] of its word). Bytes 0-15 are at 0x20-0x2C and bytes 16-31 at 0x40-0x4C. The words read back as written, and `eng_tx_byte` returns the byte selected by `eng_tx_idx`.
- R3: The receive buffer holds 32 bytes, packed the same way. Bytes 0-15 are at 0x30-0x3C and bytes 16-31 at 0x50-0x5C. Each byte is written only by `eng_rx_we`, at index `eng_rx_idx`. Bus writes to these words have no effect.
- R4: The length word keeps bits [23:0] and bit 31 as written and reads 0 in bits [30:24]. Its fields are: target address [7:0], write length [15:8], read length [23:16], and auto address/write FCS enable in bit 31. The word is driven on `cfg_len`.
- R5: A command write with bit 0 set while the engine is idle asserts `eng_start` from the next cycle. `eng_start` holds until `eng_busy` is seen and then drops. Command bit 0 reads 1 exactly while `eng_start` is high.
- R6: A fire request is ignored, with no start and command bit 0 reading 0, when `eng_busy` is high, `eng_state` is nonzero or `eng_pin_mon` is high.
- R7: The command word reads `eng_pin_mon` in bit 31 and `eng_state` in bits [27:24].
- R8: Each event input bit k sets interrupt status bit k on the next cycle and stays set. The bits are: 0 done, 1 write-FCS abort, 2 write-FCS bad, 3 connect, 4 timeout. Several bits may be set in one cycle. The done event ends the launch state machine's transaction.
- R9: Writing 1 to a status bit clears it. If an event for that bit arrives in the same cycle, the set wins.
- R10: `irq` is high exactly when some status bit [4:0] and its enable bit (word 0x18, bits [4:0]) are both set.
- R11: On a done event, status bits [31:30] take `eng_neg_res`. The captured FCS word takes `eng_cap_wfcs` in [7:0] and `eng_cap_rfcs` in [23:16]. Neither changes on bus writes.
- R12: Words 0x60-0x7C read zero, and writes to them change nothing.
- R13: The control word is a full 32-bit read/write word. The timing word keeps bits [15:0]: message period [15:8], address period [7:0]. The expected FCS word keeps bits [23:0]: write FCS [7:0], auto FCS [15:8], read FCS [23:16]. These words drive `cfg_ctrl`, `cfg_timing` and `cfg_exp_fcs`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 5 | Word address (byte offset / 4) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq | output | 1 | Interrupt request |
| eng_start | output | 1 | Start request to the engine |
| eng_busy | input | 1 | Engine is running a transaction |
| eng_state | input | 4 | Engine state code |
| eng_pin_mon | input | 1 | Pin activity seen by the engine |
| eng_evt | input | 5 | Event pulses (done, abort, FCS bad, connect, timeout) |
| eng_neg_res | input | 2 | Timing negotiation result, taken on done |
| eng_cap_wfcs | input | 8 | Captured write FCS, taken on done |
| eng_cap_rfcs | input | 8 | Captured read FCS, taken on done |
| eng_tx_idx | input | 5 | Transmit byte index |
| eng_tx_byte | output | 8 | Transmit byte at `eng_tx_idx` |
| eng_rx_we | input | 1 | Receive byte strobe |
| eng_rx_idx | input | 5 | Receive byte index |
| eng_rx_byte | input | 8 | Receive byte value |
| cfg_ctrl | output | 32 | Control word |
| cfg_timing | output | 16 | Timing periods |
| cfg_len | output | 32 | Address, lengths and auto FCS enable |
| cfg_exp_fcs | output | 24 | Expected FCS values |

## Verification
A launch state machine stuck in or skipping LS_LAUNCH shows at once as a wrong `eng_start`, and in the same cycle as a wrong command bit 0. A missed or early return to LS_IDLE shows as a fire request that is wrongly ignored or wrongly accepted on the next command write. A lost or misplaced status or buffer byte is visible on `bus_rdata` or `irq` in the cycle after the causing event. For that reason the bench compares every port against its reference model on every clock, rather than only at the end of a transaction.

// File: rtl/phr_pkg.sv
package phr_pkg;

    // Launch state machine states
    typedef enum logic [1:0] {
        LS_IDLE   = 2'd0,
        LS_LAUNCH = 2'd1,
        LS_WAIT   = 2'd2
    } launch_state_t;

    // Word addresses of the configuration and status words
    localparam logic [4:0] W_CTRL   = 5'd0;
    localparam logic [4:0] W_TIMING = 5'd1;
    localparam logic [4:0] W_CMD    = 5'd2;
    localparam logic [4:0] W_LEN    = 5'd3;
    localparam logic [4:0] W_EXPFCS = 5'd4;
    localparam logic [4:0] W_CAPFCS = 5'd5;
    localparam logic [4:0] W_IEN    = 5'd6;
    localparam logic [4:0] W_ISTS   = 5'd7;

    // Writable bits of the length/address word
    localparam logic [31:0] LEN_MASK = 32'h80FF_FFFF;

endpackage

// File: rtl/phr_launch_fsm.sv
module phr_launch_fsm
    import phr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fire_req,
    input  logic eng_idle,
    input  logic eng_busy,
    input  logic eng_done,
    output logic eng_start
);

    launch_state_t st_q;
    launch_state_t st_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= LS_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // Transitions
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            LS_IDLE: begin
                if (fire_req && eng_idle) begin
                    st_d = LS_LAUNCH;
                end
            end
            LS_LAUNCH: begin
                if (eng_done) begin
                    st_d = LS_IDLE;
                end else if (eng_busy) begin
                    st_d = LS_WAIT;
                end
            end
            LS_WAIT: begin
                if (eng_done) begin
                    st_d = LS_IDLE;
                end
            end
            default: st_d = LS_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        eng_start = 1'b0;
        unique case (st_q)
            LS_LAUNCH: eng_start = 1'b1;
            default:   eng_start = 1'b0;
        endcase
    end

    AST_START_NEEDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n) $rose(eng_start) |-> $past(fire_req && eng_idle)); // R6
    AST_START_HELD: assert property (@(posedge clk) disable iff (!rst_n) (eng_start && !eng_busy && !eng_done) |=> eng_start); // R5
    AST_START_DROPS: assert property (@(posedge clk) disable iff (!rst_n) (eng_start && eng_busy) |=> !eng_start); // R5

endmodule

// File: rtl/phr_irq_unit.sv
module phr_irq_unit #(
    parameter int EVT_N = 5,
    parameter int NEG_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EVT_N-1:0] evt,
    input  logic             clr_we,
    input  logic [EVT_N-1:0] clr_bits,
    input  logic             en_we,
    input  logic [EVT_N-1:0] en_bits,
    input  logic [NEG_W-1:0] neg_res,
    output logic [EVT_N-1:0] sts_o,
    output logic [EVT_N-1:0] en_o,
    output logic [NEG_W-1:0] neg_o,
    output logic             irq
);

    logic [EVT_N-1:0] en_q;
    logic [NEG_W-1:0] neg_q;

    // One sticky flag per event; a set in the same cycle wins over a clear
    for (genvar k = 0; k < EVT_N; k++) begin : g_flag
        logic flag_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                flag_q <= 1'b0;
            end else if (evt[k]) begin
                flag_q <= 1'b1;
            end else if (clr_we && clr_bits[k]) begin
                flag_q <= 1'b0;
            end
        end
        assign sts_o[k] = flag_q;
    end

    // Enable mask and negotiation result (taken on the done event, bit 0)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q  <= '0;
            neg_q <= '0;
        end else begin
            if (en_we) begin
                en_q <= en_bits;
            end
            if (evt[0]) begin
                neg_q <= neg_res;
            end
        end
    end

    assign en_o  = en_q;
    assign neg_o = neg_q;
    assign irq   = |(sts_o & en_q);

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n) evt[0] |=> sts_o[0]); // R8
    AST_W1C_ALL: assert property (@(posedge clk) disable iff (!rst_n) (clr_we && (&clr_bits) && (evt == '0)) |=> (sts_o == '0)); // R9
    AST_NEG_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !evt[0] |=> $stable(neg_o)); // R11

endmodule

// File: rtl/phr_tx_bank.sv
module phr_tx_bank #(
    parameter int BYTES = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         we,
    input  logic [$clog2(BYTES/4)-1:0]   widx,
    input  logic [31:0]                  wdata,
    input  logic [$clog2(BYTES/4)-1:0]   ridx,
    output logic [31:0]                  rword,
    input  logic [$clog2(BYTES)-1:0]     byte_idx,
    output logic [7:0]                   byte_out
);

    localparam int WIDX_W = $clog2(BYTES / 4);

    logic [BYTES*8-1:0] flat;

    // Bus writes whole words; byte k is lane k%4 of word k/4
    for (genvar k = 0; k < BYTES; k++) begin : g_byte
        logic [7:0] b_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                b_q <= '0;
            end else if (we && (widx == WIDX_W'(k / 4))) begin
                b_q <= wdata[8*(k%4) +: 8];
            end
        end
        assign flat[8*k +: 8] = b_q;
    end

    assign rword    = flat[{ridx, 5'b00000} +: 32];
    assign byte_out = flat[{byte_idx, 3'b000} +: 8];

endmodule

// File: rtl/phr_rx_bank.sv
module phr_rx_bank #(
    parameter int BYTES = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         byte_we,
    input  logic [$clog2(BYTES)-1:0]     byte_idx,
    input  logic [7:0]                   byte_in,
    input  logic [$clog2(BYTES/4)-1:0]   ridx,
    output logic [31:0]                  rword
);

    localparam int BIDX_W = $clog2(BYTES);

    logic [BYTES*8-1:0] flat;

    // Only the engine strobe writes here, one byte at the supplied index
    for (genvar k = 0; k < BYTES; k++) begin : g_byte
        logic [7:0] b_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                b_q <= '0;
            end else if (byte_we && (byte_idx == BIDX_W'(k))) begin
                b_q <= byte_in;
            end
        end
        assign flat[8*k +: 8] = b_q;
    end

    assign rword = flat[{ridx, 5'b00000} +: 32];

endmodule

// File: rtl/peci_host_regs.sv
module peci_host_regs
    import phr_pkg::*;
#(
    parameter int BANK_BYTES = 16,
    parameter int BANKS      = 2,
    parameter int EVT_N      = 5,
    parameter int NEG_W      = 2
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 bus_we,
    input  logic [4:0]                           bus_addr,
    input  logic [31:0]                          bus_wdata,
    output logic [31:0]                          bus_rdata,
    output logic                                 irq,
    output logic                                 eng_start,
    input  logic                                 eng_busy,
    input  logic [3:0]                           eng_state,
    input  logic                                 eng_pin_mon,
    input  logic [EVT_N-1:0]                     eng_evt,
    input  logic [NEG_W-1:0]                     eng_neg_res,
    input  logic [7:0]                           eng_cap_wfcs,
    input  logic [7:0]                           eng_cap_rfcs,
    input  logic [$clog2(BANK_BYTES*BANKS)-1:0]  eng_tx_idx,
    output logic [7:0]                           eng_tx_byte,
    input  logic                                 eng_rx_we,
    input  logic [$clog2(BANK_BYTES*BANKS)-1:0]  eng_rx_idx,
    input  logic [7:0]                           eng_rx_byte,
    output logic [31:0]                          cfg_ctrl,
    output logic [15:0]                          cfg_timing,
    output logic [31:0]                          cfg_len,
    output logic [23:0]                          cfg_exp_fcs
);

    // The word map fixes two banks of four words each per direction
    localparam int BUF_BYTES = BANK_BYTES * BANKS;
    localparam int WIDX_W    = $clog2(BUF_BYTES / 4);

    logic [31:0] ctrl_q;
    logic [15:0] timing_q;
    logic [31:0] len_q;
    logic [23:0] exp_q;
    logic [7:0]  cap_w_q;
    logic [7:0]  cap_r_q;

    logic              tx_hit;
    logic              rx_hit;
    logic [WIDX_W-1:0] buf_widx;
    logic [31:0]       tx_word;
    logic [31:0]       rx_word;
    logic              fire_req;
    logic              eng_idle;
    logic [EVT_N-1:0]  sts_flags;
    logic [EVT_N-1:0]  en_flags;
    logic [NEG_W-1:0]  neg_q;

    // Buffer windows: transmit at words 8-11 and 16-19, receive at 12-15 and 20-23
    assign tx_hit   = (bus_addr[4:2] == 3'b010) || (bus_addr[4:2] == 3'b100);
    assign rx_hit   = (bus_addr[4:2] == 3'b011) || (bus_addr[4:2] == 3'b101);
    assign buf_widx = {bus_addr[4], bus_addr[1:0]};

    // Engine counts as idle only with no busy, a zero state code and no pin activity
    assign eng_idle = !eng_busy && (eng_state == 4'd0) && !eng_pin_mon;
    assign fire_req = bus_we && (bus_addr == W_CMD) && bus_wdata[0];

    // Configuration words
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            timing_q <= '0;
            len_q    <= '0;
            exp_q    <= '0;
        end else if (bus_we) begin
            case (bus_addr)
                W_CTRL:   ctrl_q   <= bus_wdata;
                W_TIMING: timing_q <= bus_wdata[15:0];
                W_LEN:    len_q    <= bus_wdata & LEN_MASK;
                W_EXPFCS: exp_q    <= bus_wdata[23:0];
                default:  ;
            endcase
        end
    end

    // Captured FCS values, taken when the engine reports done
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_w_q <= '0;
            cap_r_q <= '0;
        end else if (eng_evt[0]) begin
            cap_w_q <= eng_cap_wfcs;
            cap_r_q <= eng_cap_rfcs;
        end
    end

    phr_launch_fsm u_launch (
        .clk       (clk),
        .rst_n     (rst_n),
        .fire_req  (fire_req),
        .eng_idle  (eng_idle),
        .eng_busy  (eng_busy),
        .eng_done  (eng_evt[0]),
        .eng_start (eng_start)
    );

    phr_irq_unit #(
        .EVT_N (EVT_N),
        .NEG_W (NEG_W)
    ) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (eng_evt),
        .clr_we   (bus_we && (bus_addr == W_ISTS)),
        .clr_bits (bus_wdata[EVT_N-1:0]),
        .en_we    (bus_we && (bus_addr == W_IEN)),
        .en_bits  (bus_wdata[EVT_N-1:0]),
        .neg_res  (eng_neg_res),
        .sts_o    (sts_flags),
        .en_o     (en_flags),
        .neg_o    (neg_q),
        .irq      (irq)
    );

    phr_tx_bank #(
        .BYTES (BUF_BYTES)
    ) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (bus_we && tx_hit),
        .widx     (buf_widx),
        .wdata    (bus_wdata),
        .ridx     (buf_widx),
        .rword    (tx_word),
        .byte_idx (eng_tx_idx),
        .byte_out (eng_tx_byte)
    );

    phr_rx_bank #(
        .BYTES (BUF_BYTES)
    ) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .byte_we  (eng_rx_we),
        .byte_idx (eng_rx_idx),
        .byte_in  (eng_rx_byte),
        .ridx     (buf_widx),
        .rword    (rx_word)
    );

    // Read multiplexer; anything not decoded returns zero
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            W_CTRL:   bus_rdata = ctrl_q;
            W_TIMING: bus_rdata = {16'h0000, timing_q};
            W_CMD:    bus_rdata = {eng_pin_mon, 3'b000, eng_state, 23'h0, eng_start};
            W_LEN:    bus_rdata = len_q;
            W_EXPFCS: bus_rdata = {8'h00, exp_q};
            W_CAPFCS: bus_rdata = {8'h00, cap_r_q, 8'h00, cap_w_q};
            W_IEN:    bus_rdata = {{(32-EVT_N){1'b0}}, en_flags};
            W_ISTS:   bus_rdata = {neg_q, {(32-NEG_W-EVT_N){1'b0}}, sts_flags};
            default: begin
                if (tx_hit) begin
                    bus_rdata = tx_word;
                end else if (rx_hit) begin
                    bus_rdata = rx_word;
                end
            end
        endcase
    end

    assign cfg_ctrl    = ctrl_q;
    assign cfg_timing  = timing_q;
    assign cfg_len     = len_q;
    assign cfg_exp_fcs = exp_q;

    AST_CAP_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n) eng_evt[0] |=> (cap_r_q == $past(eng_cap_rfcs))); // R11
    AST_LEN_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n) bus_we |=> (cfg_len[30:24] == 7'd0)); // R4

endmodule

// File: tb/test_peci_host_regs.sv
module test_peci_host_regs;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_we;
    logic [4:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        irq;
    logic        eng_start;
    logic        eng_busy;
    logic [3:0]  eng_state;
    logic        eng_pin_mon;
    logic [4:0]  eng_evt;
    logic [1:0]  eng_neg_res;
    logic [7:0]  eng_cap_wfcs;
    logic [7:0]  eng_cap_rfcs;
    logic [4:0]  eng_tx_idx;
    logic [7:0]  eng_tx_byte;
    logic        eng_rx_we;
    logic [4:0]  eng_rx_idx;
    logic [7:0]  eng_rx_byte;
    logic [31:0] cfg_ctrl;
    logic [15:0] cfg_timing;
    logic [31:0] cfg_len;
    logic [23:0] cfg_exp_fcs;

    always #10 clk = ~clk;

    peci_host_regs i_peci_host_regs (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
        .eng_start(eng_start), .eng_busy(eng_busy), .eng_state(eng_state),
        .eng_pin_mon(eng_pin_mon), .eng_evt(eng_evt), .eng_neg_res(eng_neg_res),
        .eng_cap_wfcs(eng_cap_wfcs), .eng_cap_rfcs(eng_cap_rfcs),
        .eng_tx_idx(eng_tx_idx), .eng_tx_byte(eng_tx_byte),
        .eng_rx_we(eng_rx_we), .eng_rx_idx(eng_rx_idx), .eng_rx_byte(eng_rx_byte),
        .cfg_ctrl(cfg_ctrl), .cfg_timing(cfg_timing), .cfg_len(cfg_len),
        .cfg_exp_fcs(cfg_exp_fcs)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [7:0]  m_tx [32];
    logic [7:0]  m_rx [32];
    int          m_fsm;
    bit          m_idle;
    logic [31:0] m_ctrl, m_len, m_cap;
    logic [15:0] m_timing;
    logic [23:0] m_exp;
    logic [4:0]  m_ien, m_ists;
    logic [1:0]  m_neg;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 32; i++) begin
                m_tx[i] = 8'h00;
                m_rx[i] = 8'h00;
            end
            m_fsm = 0; m_ctrl = 0; m_len = 0; m_cap = 0; m_timing = 0;
            m_exp = 0; m_ien = 0; m_ists = 0; m_neg = 0;
        end else begin
            m_idle = !eng_busy && (eng_state == 4'd0) && !eng_pin_mon;
            case (m_fsm)
                0: if (bus_we && bus_addr == 5'd2 && bus_wdata[0] && m_idle) m_fsm = 1;
                1: if (eng_evt[0]) m_fsm = 0; else if (eng_busy) m_fsm = 2;
                default: if (eng_evt[0]) m_fsm = 0;
            endcase
            for (int k = 0; k < 5; k++) begin
                if (eng_evt[k]) m_ists[k] = 1'b1;
                else if (bus_we && bus_addr == 5'd7 && bus_wdata[k]) m_ists[k] = 1'b0;
            end
            if (eng_evt[0]) begin
                m_neg = eng_neg_res;
                m_cap = {8'h00, eng_cap_rfcs, 8'h00, eng_cap_wfcs};
            end
            if (bus_we) begin
                case (bus_addr)
                    5'd0: m_ctrl = bus_wdata;
                    5'd1: m_timing = bus_wdata[15:0];
                    5'd3: m_len = {bus_wdata[31], 7'd0, bus_wdata[23:0]};
                    5'd4: m_exp = bus_wdata[23:0];
                    5'd6: m_ien = bus_wdata[4:0];
                    default: ;
                endcase
                if (bus_addr >= 5'd8 && bus_addr <= 5'd11)
                    for (int b = 0; b < 4; b++) m_tx[(int'(bus_addr) - 8) * 4 + b] = bus_wdata[8*b +: 8];
                if (bus_addr >= 5'd16 && bus_addr <= 5'd19)
                    for (int b = 0; b < 4; b++) m_tx[16 + (int'(bus_addr) - 16) * 4 + b] = bus_wdata[8*b +: 8];
            end
            if (eng_rx_we) m_rx[eng_rx_idx] = eng_rx_byte;
        end
    end

    function automatic logic [31:0] m_rdata(logic [4:0] a);
        int base;
        if (a >= 5'd8 && a <= 5'd11) begin
            base = (int'(a) - 8) * 4;
            return {m_tx[base+3], m_tx[base+2], m_tx[base+1], m_tx[base]};
        end
        if (a >= 5'd16 && a <= 5'd19) begin
            base = 16 + (int'(a) - 16) * 4;
            return {m_tx[base+3], m_tx[base+2], m_tx[base+1], m_tx[base]};
        end
        if (a >= 5'd12 && a <= 5'd15) begin
            base = (int'(a) - 12) * 4;
            return {m_rx[base+3], m_rx[base+2], m_rx[base+1], m_rx[base]};
        end
        if (a >= 5'd20 && a <= 5'd23) begin
            base = 16 + (int'(a) - 20) * 4;
            return {m_rx[base+3], m_rx[base+2], m_rx[base+1], m_rx[base]};
        end
        case (a)
            5'd0: return m_ctrl;
            5'd1: return {16'h0, m_timing};
            5'd2: return {eng_pin_mon, 3'b000, eng_state, 23'h0, (m_fsm == 1)};
            5'd3: return m_len;
            5'd4: return {8'h00, m_exp};
            5'd5: return m_cap;
            5'd6: return {27'h0, m_ien};
            5'd7: return {m_neg, 25'h0, m_ists};
            default: return 32'h0;
        endcase
    endfunction

    // Per-cycle comparison, mid-cycle after the stimulus has settled
    always @(negedge clk) begin
        #5;
        if (rst_n && !finished) begin
            chk("R1 R12 model bus_rdata", bus_rdata, m_rdata(bus_addr));
            chk("R5 model eng_start", {31'h0, eng_start}, {31'h0, (m_fsm == 1)});
            chk("R10 model irq", {31'h0, irq}, {31'h0, |(m_ists & m_ien)});
            chk("R2 model eng_tx_byte", {24'h0, eng_tx_byte}, {24'h0, m_tx[eng_tx_idx]});
            chk("R13 model cfg_ctrl", cfg_ctrl, m_ctrl);
            chk("R13 model cfg_timing", {16'h0, cfg_timing}, {16'h0, m_timing});
            chk("R13 model cfg_exp_fcs", {8'h0, cfg_exp_fcs}, {8'h0, m_exp});
            chk("R4 model cfg_len", cfg_len, m_len);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(logic [4:0] a, logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(logic [4:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_addr = a;
        #2;
        v = bus_rdata;
    endtask

    task automatic txn(int nrx, logic [7:0] base, logic [4:0] evts, logic [1:0] neg,
                       logic [7:0] wf, logic [7:0] rf);
        int guard;
        guard = 0;
        while (!eng_start && guard < 50) begin
            @(negedge clk);
            guard++;
        end
        eng_busy = 1'b1; eng_state = 4'h3;
        for (int i = 0; i < nrx; i++) begin
            @(negedge clk);
            eng_rx_we = 1'b1; eng_rx_idx = i[4:0]; eng_rx_byte = base + i[7:0];
        end
        @(negedge clk);
        eng_rx_we = 1'b0;
        eng_evt = evts | 5'b00001; eng_neg_res = neg; eng_cap_wfcs = wf; eng_cap_rfcs = rf;
        @(negedge clk);
        eng_evt = 5'b0; eng_busy = 1'b0; eng_state = 4'h0;
        @(negedge clk);
    endtask

    task automatic finish_run();
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL R5 watchdog actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        logic [31:0] v;
        rst_n = 1'b0; bus_we = 1'b0; bus_addr = 5'd0; bus_wdata = 32'h0;
        eng_busy = 1'b0; eng_state = 4'h0; eng_pin_mon = 1'b0; eng_evt = 5'h0;
        eng_neg_res = 2'b00; eng_cap_wfcs = 8'h00; eng_cap_rfcs = 8'h00;
        eng_tx_idx = 5'd0; eng_rx_we = 1'b0; eng_rx_idx = 5'd0; eng_rx_byte = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values
        for (int a = 0; a < 32; a++) begin
            rd(a[4:0], v);
            chk("R1 reset word", v, 32'h0);
        end
        chk("R1 reset irq", {31'h0, irq}, 32'h0);
        chk("R1 reset eng_start", {31'h0, eng_start}, 32'h0);

        // R13 / R4: configuration words
        wr(5'd0, 32'hA5A5_0F0F); rd(5'd0, v); chk("R13 control", v, 32'hA5A5_0F0F);
        wr(5'd1, 32'h1234_ABCD); rd(5'd1, v); chk("R13 timing", v, 32'h0000_ABCD);
        wr(5'd4, 32'hFFFF_FFFF); rd(5'd4, v); chk("R13 expected fcs", v, 32'h00FF_FFFF);
        wr(5'd3, 32'hFFFF_FFFF); rd(5'd3, v); chk("R4 length word", v, 32'h80FF_FFFF);
        chk("R4 cfg_len", cfg_len, 32'h80FF_FFFF);
        wr(5'd3, 32'h0004_0230); rd(5'd3, v); chk("R4 length fields", v, 32'h0004_0230);

        // R2: transmit buffer in both banks
        wr(5'd8, 32'h4433_2211);
        wr(5'd19, 32'hDDCC_BBAA);
        rd(5'd8, v);  chk("R2 tx word 0x20", v, 32'h4433_2211);
        rd(5'd19, v); chk("R2 tx word 0x4C", v, 32'hDDCC_BBAA);
        eng_tx_idx = 5'd1;  #1 chk("R2 tx byte 1", {24'h0, eng_tx_byte}, 32'h22);
        eng_tx_idx = 5'd31; #1 chk("R2 tx byte 31", {24'h0, eng_tx_byte}, 32'hDD);
        eng_tx_idx = 5'd28; #1 chk("R2 tx byte 28", {24'h0, eng_tx_byte}, 32'hAA);

        // R6: fire ignored while engine not idle; R7 command readback
        eng_busy = 1'b1;
        wr(5'd2, 32'h1); repeat (2) @(negedge clk);
        #1 chk("R6 busy no start", {31'h0, eng_start}, 32'h0);
        rd(5'd2, v); chk("R6 busy fire bit", v, 32'h0);
        eng_busy = 1'b0; eng_pin_mon = 1'b1;
        wr(5'd2, 32'h1); repeat (2) @(negedge clk);
        #1 chk("R6 pin activity no start", {31'h0, eng_start}, 32'h0);
        eng_pin_mon = 1'b0; eng_state = 4'h5;
        wr(5'd2, 32'h1); repeat (2) @(negedge clk);
        #1 chk("R6 state nonzero no start", {31'h0, eng_start}, 32'h0);
        eng_pin_mon = 1'b1;
        rd(5'd2, v); chk("R7 command status", v, 32'h8500_0000);
        eng_pin_mon = 1'b0; eng_state = 4'h0;

        // R5, R8, R3, R11, R10: first transaction
        wr(5'd6, 32'h1F);
        wr(5'd2, 32'h1);
        #1 chk("R5 start raised", {31'h0, eng_start}, 32'h1);
        rd(5'd2, v); chk("R5 fire bit pending", v, 32'h1);
        repeat (2) @(negedge clk);
        #1 chk("R5 start held", {31'h0, eng_start}, 32'h1);
        txn(4, 8'h10, 5'b00100, 2'b10, 8'h3C, 8'hC3);
        chk("R5 start dropped", {31'h0, eng_start}, 32'h0);
        rd(5'd2, v);  chk("R5 fire bit cleared", v, 32'h0);
        rd(5'd7, v);  chk("R8 status after done", v, 32'h8000_0005);
        rd(5'd5, v);  chk("R11 captured fcs", v, 32'h00C3_003C);
        rd(5'd12, v); chk("R3 rx word 0x30", v, 32'h1312_1110);
        chk("R10 irq raised", {31'h0, irq}, 32'h1);

        // R9: write-one-to-clear and set-wins
        wr(5'd7, 32'h1); rd(5'd7, v); chk("R9 clear done bit", v, 32'h8000_0004);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = 5'd7; bus_wdata = 32'h8; eng_evt = 5'b01000;
        @(negedge clk);
        bus_we = 1'b0; eng_evt = 5'b0;
        rd(5'd7, v); chk("R9 set wins over clear", v, 32'h8000_000C);
        wr(5'd6, 32'h1);
        #1 chk("R10 masked irq low", {31'h0, irq}, 32'h0);
        wr(5'd6, 32'h8);
        #1 chk("R10 enabled connect irq", {31'h0, irq}, 32'h1);
        wr(5'd7, 32'hFFFF_FFFF); rd(5'd7, v); chk("R11 result kept after clear", v, 32'h8000_0000);
        chk("R9 irq after clear all", {31'h0, irq}, 32'h0);

        // Second transaction: all events at once, upper receive bank
        wr(5'd6, 32'h1);
        wr(5'd2, 32'h1);
        txn(20, 8'h80, 5'b11111, 2'b01, 8'h11, 8'h22);
        rd(5'd7, v);  chk("R8 all events in one cycle", v, 32'h4000_001F);
        rd(5'd20, v); chk("R3 rx word 0x50", v, 32'h9392_9190);
        rd(5'd12, v); chk("R3 rx word 0x30 rewritten", v, 32'h8382_8180);
        rd(5'd5, v);  chk("R11 captured fcs second", v, 32'h0022_0011);
        chk("R10 irq on done", {31'h0, irq}, 32'h1);

        // R12 / R3 / R11: writes with no effect
        wr(5'd24, 32'hFFFF_FFFF); rd(5'd24, v); chk("R12 unmapped 0x60", v, 32'h0);
        wr(5'd31, 32'hFFFF_FFFF); rd(5'd31, v); chk("R12 unmapped 0x7C", v, 32'h0);
        rd(5'd0, v); chk("R12 control untouched", v, 32'hA5A5_0F0F);
        wr(5'd5, 32'hFFFF_FFFF); rd(5'd5, v); chk("R11 captured fcs read only", v, 32'h0022_0011);
        wr(5'd12, 32'h0); rd(5'd12, v); chk("R3 rx bus write ignored", v, 32'h8382_8180);

        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule